// File: doc/BRIEF.md
# Predication Mask Redirection Table

This block maps the register operand of an instruction to the predicate register that masks it. Software loads up to sixteen entries. Each entry is one 16-bit control word, plus a 7-bit predicate register number that arrives alongside it on the same write. The control word names an operand register and says whether that register is integer or floating point. It also carries three per-entry flags: zeroing, invert and fail-first.

At lookup time the decoder presents an operand register number and the integer/floating-point selector. The block answers combinationally with:
- whether predication applies;
- the full 7-bit predicate register to read;
- the three flags;
- a 5-bit tag field.

When the caller also supplies the raw predicate register value, the block returns the effective element mask. It inverts that mask when the entry asks for it; the stored register is never altered. An operand with no matching entry is unpredicated, so the mask is all ones.

Entry writes land on the next rising clock. An active-low reset empties the table.

Top module: `pred_redir_table`

## Requirements
- R1: While `rst_ni` is low, and after it returns high with no write since, every lookup misses.
- R2: A write to entry `wr_idx_i` is not visible to a lookup in the cycle it is presented. It becomes visible from the cycle after the next rising clock.
- R3: Control word layout:
  - bits 15..11 are a tag returned on `lk_tag_o`;
  - bit 10 is zeroing, returned on `lk_zero_o`;
  - bit 9 is invert, returned on `lk_inv_o`;
  - bit 0 is fail-first, returned on `lk_ffirst_o`.
- R4: A lookup hits only when a written entry has bit 8 equal to `lk_fp_i` (0 integer, 1 floating point) and bits 7..1 equal to `lk_reg_i`. The same register number under the other selector misses.
- R5: On a hit, `lk_pred_reg_o` equals the 7-bit `wr_pred_reg_i` value written with the winning entry.
- R6: On a hit, `mask_o` equals the low MASK_W bits of `pred_val_i`, bitwise inverted when the invert flag is set.
- R7: On a miss, all of the following hold:
  - `lk_hit_o` is 0;
  - every flag, the tag and `lk_pred_reg_o` are 0;
  - `mask_o` is all ones.
- R8: When several written entries match the same selector and register, the one with the highest entry index supplies the result.
- R9: Rewriting an entry replaces its previous mapping entirely. The old selector and register no longer hit through that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | $clog2(N_ENTRIES) | Entry number written |
| wr_word_i | input | 16 | Entry control word |
| wr_pred_reg_i | input | 7 | Predicate register for the entry |
| lk_fp_i | input | 1 | Lookup selector, 1 = floating point |
| lk_reg_i | input | 7 | Operand register looked up |
| pred_val_i | input | PRED_W | Raw predicate register value |
| lk_hit_o | output | 1 | Predication enabled for this operand |
| lk_pred_reg_o | output | 7 | Redirected predicate register |
| lk_zero_o | output | 1 | Zeroing flag |
| lk_inv_o | output | 1 | Invert flag |
| lk_ffirst_o | output | 1 | Fail-first flag |
| lk_tag_o | output | 5 | Tag field of the winning entry |
| mask_o | output | MASK_W | Effective element mask |

## Verification
The assertions assume that `wr_idx_i` always names an existing entry. They also assume that `wr_en_i` is low during reset and in the first cycle after it, so that entry contents change only through a write.

The bench keeps to these limits:
- it draws entry numbers below N_ENTRIES;
- it holds the write strobe low around every reset.

Operand and entry register numbers are drawn from a small set, so matches and duplicate mappings happen often.

// File: rtl/pred_redir_pkg.sv
package pred_redir_pkg;
  localparam int WORD_W = 16;
  localparam int REG_W  = 7;
  localparam int TAG_W  = 5;

  // field order follows the control word, bit 15 first
  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             zero;
    logic             inv;
    logic             fp;
    logic [REG_W-1:0] reg_sel;
    logic             ffirst;
  } pred_word_t;

  typedef struct packed {
    pred_word_t       w;
    logic [REG_W-1:0] pred_reg;
  } pred_entry_t;
endpackage

// File: rtl/pred_entry_store.sv
module pred_entry_store
  import pred_redir_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [WORD_W-1:0]      wr_word_i,
  input  logic [REG_W-1:0]       wr_pred_reg_i,
  output logic [N_ENTRIES-1:0]   valid_o,
  output pred_entry_t            entry_o [N_ENTRIES]
);
  logic [N_ENTRIES-1:0] valid_q;
  pred_entry_t          entry_q [N_ENTRIES];
  pred_entry_t          entry_d;

  assign entry_d = '{w: pred_word_t'(wr_word_i), pred_reg: wr_pred_reg_i};

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        entry_q[g] <= '0;
      end else if (sel) begin
        valid_q[g] <= 1'b1;
        entry_q[g] <= entry_d;
      end
    end
    assign entry_o[g] = entry_q[g];
  end

  assign valid_o = valid_q;

  // R2
  wr_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_idx_i)] && (entry_q[$past(wr_idx_i)] == $past(entry_d)));

  // R2
  valid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable(valid_q));
endmodule

// File: rtl/pred_lookup.sv
module pred_lookup
  import pred_redir_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_ENTRIES-1:0] valid_i,
  input  pred_entry_t          entry_i [N_ENTRIES],
  input  logic                 fp_i,
  input  logic [REG_W-1:0]     reg_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     sel_o,
  output pred_entry_t          entry_o
);
  logic [N_ENTRIES-1:0] match;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (entry_i[g].w.fp == fp_i) && (entry_i[g].w.reg_sel == reg_i);
  end

  // later entries overwrite earlier ones: highest index wins
  always_comb begin
    sel_o = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (match[i]) sel_o = IDX_W'(i);
    end
  end

  assign hit_o   = |match;
  assign entry_o = hit_o ? entry_i[sel_o] : '0;

  // R4
  hit_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> valid_i[sel_o] && entry_o.w.fp == fp_i && entry_o.w.reg_sel == reg_i);

  // R1
  miss_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i == '0) |-> !hit_o);
endmodule

// File: rtl/pred_mask_gen.sv
module pred_mask_gen #(
  parameter int MASK_W = 64,
  parameter int PRED_W = 64
) (
  input  logic              hit_i,
  input  logic              inv_i,
  input  logic [PRED_W-1:0] pred_val_i,
  output logic [MASK_W-1:0] mask_o
);
  logic [MASK_W-1:0] raw;
  assign raw = pred_val_i[MASK_W-1:0];

  always_comb begin
    if (!hit_i)     mask_o = '1;
    else if (inv_i) mask_o = ~raw;
    else            mask_o = raw;
  end
endmodule

// File: rtl/pred_redir_table.sv
module pred_redir_table
  import pred_redir_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int MASK_W    = 64,
  parameter int PRED_W    = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [$clog2(N_ENTRIES)-1:0]  wr_idx_i,
  input  logic [15:0]                   wr_word_i,
  input  logic [6:0]                    wr_pred_reg_i,
  input  logic                          lk_fp_i,
  input  logic [6:0]                    lk_reg_i,
  input  logic [PRED_W-1:0]             pred_val_i,
  output logic                          lk_hit_o,
  output logic [6:0]                    lk_pred_reg_o,
  output logic                          lk_zero_o,
  output logic                          lk_inv_o,
  output logic                          lk_ffirst_o,
  output logic [4:0]                    lk_tag_o,
  output logic [MASK_W-1:0]             mask_o
);
  localparam int IDX_W = $clog2(N_ENTRIES);

  logic [N_ENTRIES-1:0] valid;
  pred_entry_t          entries [N_ENTRIES];
  pred_entry_t          win;
  logic [IDX_W-1:0]     win_idx;

  pred_entry_store #(.N_ENTRIES(N_ENTRIES)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_word_i, .wr_pred_reg_i,
    .valid_o(valid), .entry_o(entries)
  );

  pred_lookup #(.N_ENTRIES(N_ENTRIES)) u_lookup (
    .clk_i, .rst_ni, .valid_i(valid), .entry_i(entries),
    .fp_i(lk_fp_i), .reg_i(lk_reg_i),
    .hit_o(lk_hit_o), .sel_o(win_idx), .entry_o(win)
  );

  pred_mask_gen #(.MASK_W(MASK_W), .PRED_W(PRED_W)) u_mask (
    .hit_i(lk_hit_o), .inv_i(win.w.inv), .pred_val_i, .mask_o
  );

  assign lk_pred_reg_o = win.pred_reg;
  assign lk_zero_o     = win.w.zero;
  assign lk_inv_o      = win.w.inv;
  assign lk_ffirst_o   = win.w.ffirst;
  assign lk_tag_o      = win.w.tag;

  // R7
  miss_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (&mask_o) && !lk_inv_o && !lk_zero_o && !lk_ffirst_o && lk_pred_reg_o == '0);

  // R6
  inv_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && lk_inv_o) |-> mask_o == ~pred_val_i[MASK_W-1:0]);

  // R6
  pass_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && !lk_inv_o) |-> mask_o == pred_val_i[MASK_W-1:0]);
endmodule

// File: tb/pred_redir_table_tb_top.sv
`timescale 1ns/1ps
module pred_redir_table_tb_top;
  localparam int N = 16;
  localparam int MW = 64;
  localparam int PW = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_idx = '0;
  logic [15:0]   wr_word = '0;
  logic [6:0]    wr_preg = '0;
  logic          lk_fp = 1'b0;
  logic [6:0]    lk_reg = '0;
  logic [PW-1:0] pval = '0;
  logic          hit, zero, inv, ffirst;
  logic [6:0]    preg;
  logic [4:0]    tag;
  logic [MW-1:0] mask;

  int n_cmp = 0;
  int n_bad = 0;

  bit        m_valid [N];
  bit [15:0] m_word  [N];
  bit [6:0]  m_preg  [N];

  always #4 clk = ~clk;

  pred_redir_table #(.N_ENTRIES(N), .MASK_W(MW), .PRED_W(PW)) dut_i (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_word_i(wr_word),
    .wr_pred_reg_i(wr_preg), .lk_fp_i(lk_fp), .lk_reg_i(lk_reg), .pred_val_i(pval),
    .lk_hit_o(hit), .lk_pred_reg_o(preg), .lk_zero_o(zero), .lk_inv_o(inv),
    .lk_ffirst_o(ffirst), .lk_tag_o(tag), .mask_o(mask)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference: scan all entries in order, the last match wins
  task automatic compare(string note);
    int pick = -1;
    logic [MW-1:0] em;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_word[i][8] == lk_fp && m_word[i][7:1] == lk_reg) pick = i;
    if (pick < 0) begin
      chk({"R7 ", note}, "hit", 64'(hit), 64'd0);
      chk({"R7 ", note}, "flags", {preg, zero, inv, ffirst, tag}, '0);
      chk({"R7 ", note}, "mask", 64'(mask), 64'(~(MW)'(0)));
    end else begin
      chk({"R4 ", note}, "hit", 64'(hit), 64'd1);
      chk({"R5 ", note}, "pred_reg", 64'(preg), 64'(m_preg[pick]));
      chk({"R3 ", note}, "flags", {zero, inv, ffirst, tag},
          {m_word[pick][10], m_word[pick][9], m_word[pick][0], m_word[pick][15:11]});
      em = m_word[pick][9] ? ~pval[MW-1:0] : pval[MW-1:0];
      chk({"R6 ", note}, "mask", 64'(mask), 64'(em));
    end
  endtask

  task automatic step(bit we, int idx, logic [15:0] w, logic [6:0] pr,
                      bit fp, logic [6:0] rg, logic [PW-1:0] v, string note);
    wr_en = we; wr_idx = 4'(idx); wr_word = w; wr_preg = pr;
    lk_fp = fp; lk_reg = rg; pval = v;
    #2 compare(note);
    @(posedge clk);
    #1;
    if (we && rst_ni) begin
      m_valid[idx] = 1'b1; m_word[idx] = w; m_preg[idx] = pr;
    end
    @(negedge clk);
  endtask

  function automatic logic [15:0] mk(logic [4:0] t, bit z, bit iv, bit fp, logic [6:0] r, bit ff);
    return {t, z, iv, fp, r, ff};
  endfunction

  task automatic do_reset();
    wr_en = 1'b0;
    rst_ni = 1'b0;
    for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    #2 compare("R1 in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    step(0, 0, '0, '0, 0, 7'd3, 64'h1234, "R1 after reset");
  endtask

  initial begin
    #(200000 * 8);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    repeat (2) @(negedge clk);
    do_reset();
    for (int r = 0; r < 4; r++)
      step(0, 0, '0, '0, r[0], 7'(r), 64'hFFFF_0000, "R1 empty table");

    // R2: write entry 2, int reg 5 -> pred reg 40; same-cycle lookup must miss
    step(1, 2, mk(5'h11, 1, 0, 0, 7'd5, 1), 7'd40, 0, 7'd5, 64'hA5A5, "R2 same cycle");
    step(0, 0, '0, '0, 0, 7'd5, 64'hA5A5, "R2 next cycle");
    // R4: other selector misses
    step(0, 0, '0, '0, 1, 7'd5, 64'hA5A5, "R4 other selector");
    // R6: invert entry in fp table
    step(1, 7, mk(5'h03, 0, 1, 1, 7'd5, 0), 7'd99, 1, 7'd5, 64'h0F0F, "R6 write");
    step(0, 0, '0, '0, 1, 7'd5, 64'h0F0F_1234_5678_9ABC, "R6 inverted");
    // R8: entry 9 duplicates entry 2's key; higher wins
    step(1, 9, mk(5'h1F, 0, 1, 0, 7'd5, 0), 7'd127, 0, 7'd5, 64'h1, "R8 write");
    step(0, 0, '0, '0, 0, 7'd5, 64'hDEAD_BEEF, "R8 higher wins");
    // R9: rewrite entry 9 to a different register; entry 2 serves again
    step(1, 9, mk(5'h02, 1, 0, 0, 7'd6, 1), 7'd12, 0, 7'd5, 64'h77, "R9 write");
    step(0, 0, '0, '0, 0, 7'd5, 64'h77, "R9 old key");
    step(0, 0, '0, '0, 0, 7'd6, 64'h77, "R9 new key");
    // R1: reset mid-run empties the table
    do_reset();
    step(0, 0, '0, '0, 0, 7'd6, 64'h5, "R1 cleared");

    for (int k = 0; k < 3000; k++) begin
      bit we = ($urandom_range(0, 9) < 3);
      logic [15:0] w = 16'($urandom);
      w[7:1] = 7'($urandom_range(0, 3));
      step(we, $urandom_range(0, N - 1), w, 7'($urandom), 1'($urandom),
           7'($urandom_range(0, 3)), {32'($urandom), 32'($urandom)}, "random R8 R9");
      if (k == 1500) do_reset();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule